// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Thresholds

This block is a first-in first-out buffer that sits between two unrelated clock domains. A producer pushes words on its own clock whenever its write enable is high, and a consumer pops words on a second clock with its own read enable. Occupancy is reported through five status flags. The empty and full flags gate the two enables, so a write into a full buffer or a read from an empty one does nothing. The half-full flag reports occupancy above half the depth. The almost-empty and almost-full flags compare occupancy and free space against two threshold registers.

The two threshold registers take a preset value at master reset. The preset is chosen by a 3-bit select input. After reset, software can overwrite both registers through a one-bit serial port clocked by the write clock. A partial reset empties the buffer and keeps the thresholds. A master reset empties the buffer and also restores the preset thresholds. An output-enable input qualifies the read data. While it is low, the data bus reads as zero and the valid output is low.

Top module: `pflag_fifo`

## Requirements
- R1: Every accepted word comes out on `rd_data` in write order, one read-clock cycle after the read that consumed it.
- R2: `full` is high when DEPTH words are stored. A write while `full` is high is dropped and stores nothing.
- R3: `empty` is high when no word is stored. A read while `empty` is high is ignored and does not advance the read position.
- R4: `half_full` is high exactly when occupancy exceeds DEPTH/2.
- R5: `almost_empty` is high when occupancy is less than or equal to the empty threshold.
- R6: `almost_full` is high when free space (DEPTH minus occupancy) is less than or equal to the full threshold.
- R7: While `mrst` is high, both thresholds load the preset 2^(`preset_sel`+3)-1, limited to DEPTH-1.
- R8: While `ser_en` is high, each write-clock edge stores `ser_din` into the next threshold bit. The order is 2*AW bits: the empty threshold first, then the full threshold, each least significant bit first.
- R9: `prst` empties the buffer (empty=1, full=0, almost_full=0) and leaves both thresholds unchanged.
- R10: `mrst` empties the buffer and restores the preset thresholds. After it, empty=1, almost_empty=1, full=0, half_full=0 and almost_full=0.
- R11: While `oe` is low, `rd_data` is all zeros and `rd_vld` is low. While `oe` is high, `rd_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, active high, seen by both clocks |
| prst | input | 1 | Partial reset, synchronous, active high, seen by both clocks |
| preset_sel | input | 3 | Threshold preset select, sampled while mrst is high |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| ser_en | input | 1 | Serial threshold load enable |
| ser_din | input | 1 | Serial threshold data bit |
| rd_en | input | 1 | Read request |
| oe | input | 1 | Output enable / data qualifier |
| rd_data | output | DW | Read data, zero while oe is low |
| rd_vld | output | 1 | Read data qualifier, equals oe |
| empty | output | 1 | No stored words (read domain) |
| full | output | 1 | DEPTH stored words (write domain) |
| half_full | output | 1 | Occupancy above DEPTH/2 (write domain) |
| almost_empty | output | 1 | Occupancy at or below empty threshold (read domain) |
| almost_full | output | 1 | Free space at or below full threshold (write domain) |

## Verification
The bench overfills the buffer by four words and then reads past empty. If the design let a full write through, a stale word would overwrite the oldest entry and the scoreboard would report out-of-order data. If the design let an empty read move the pointer, the single word written afterwards would come out wrong or never come out. Every threshold flag is probed one step either side of its edge: occupancy 7/8, 32/33 and 56/57 for the presets, and 3/4 and 58/59 after a serial load. An off-by-one compare, or a serial load in the wrong bit order, therefore shows up as a flag in the wrong state. A partial reset after a serial load shows whether the thresholds survive it. A later master reset shows whether the preset comes back. Preset selects 2 and 5 check the table value and the DEPTH-1 limit.

// File: rtl/pff_pkg.sv
`timescale 1ns/1ps
package pff_pkg;
  localparam int unsigned PRESET_MIN_LOG = 3;

  // preset threshold: 2^(sel+3)-1, limited to depth-1
  function automatic int unsigned preset_offset(input logic [2:0] sel, input int unsigned depth);
    int unsigned v;
    v = (32'd1 << (32'(sel) + PRESET_MIN_LOG)) - 32'd1;
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction
endpackage

// File: rtl/pff_sync2.sv
`timescale 1ns/1ps
module pff_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pff_ram.sv
`timescale 1ns/1ps
module pff_ram #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pff_wr_ctl.sv
`timescale 1ns/1ps
module pff_wr_ctl #(
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          rst_ptr,
  input  logic          mrst,
  input  logic [2:0]    preset_sel,
  input  logic          wr_en,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic [AW:0]   rgray_s,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic          full,
  output logic          half_full,
  output logic          almost_full,
  output logic [AW-1:0] ae_off
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = 2 * AW;
  localparam int SW    = $clog2(CW);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wptr_q, wptr_nxt, rsync_bin, cnt_nxt, free_nxt;
  logic [CW-1:0] cfg_q;
  logic [SW-1:0] sidx_q;
  logic [AW-1:0] af_off, preset_v;

  assign preset_v  = AW'(pff_pkg::preset_offset(preset_sel, DEPTH));
  assign ae_off    = cfg_q[AW-1:0];
  assign af_off    = cfg_q[CW-1:AW];
  assign we        = wr_en && !full;
  assign waddr     = wptr_q[AW-1:0];
  assign wptr_nxt  = wptr_q + PW'(we);
  assign rsync_bin = g2b(rgray_s);
  assign cnt_nxt   = wptr_nxt - rsync_bin;
  assign free_nxt  = PW'(DEPTH) - cnt_nxt;

  always_ff @(posedge wclk) begin
    if (rst_ptr) begin
      wptr_q      <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      half_full   <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wptr_q      <= wptr_nxt;
      wgray       <= wptr_nxt ^ (wptr_nxt >> 1);
      full        <= cnt_nxt == PW'(DEPTH);
      half_full   <= cnt_nxt > PW'(DEPTH / 2);
      almost_full <= free_nxt <= {1'b0, af_off};
    end
  end

  // threshold registers: preset on master reset, serial load afterwards
  always_ff @(posedge wclk) begin
    if (mrst) begin
      cfg_q  <= {preset_v, preset_v};
      sidx_q <= '0;
    end else if (ser_en) begin
      cfg_q[sidx_q] <= ser_din;
      sidx_q        <= (sidx_q == SW'(CW - 1)) ? '0 : sidx_q + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst_ptr) (wptr_q - rsync_bin) <= PW'(DEPTH)); // R2
  AST_FULL_DROPS_WRITE: assert property (@(posedge wclk) disable iff (rst_ptr) (full && wr_en) |=> (wptr_q == $past(wptr_q))); // R2
  AST_FULL_IS_HALF: assert property (@(posedge wclk) disable iff (rst_ptr) full |-> half_full); // R4
  AST_FULL_IS_ALMOST: assert property (@(posedge wclk) disable iff (rst_ptr) full |-> almost_full); // R6
endmodule

// File: rtl/pff_rd_ctl.sv
`timescale 1ns/1ps
module pff_rd_ctl #(
  parameter int AW = 6
) (
  input  logic          rclk,
  input  logic          rst_ptr,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rptr_q, rptr_nxt, wsync_bin, occ_nxt;

  assign re        = rd_en && !empty;
  assign raddr     = rptr_q[AW-1:0];
  assign rptr_nxt  = rptr_q + PW'(re);
  assign wsync_bin = g2b(wgray_s);
  assign occ_nxt   = wsync_bin - rptr_nxt;

  always_ff @(posedge rclk) begin
    if (rst_ptr) begin
      rptr_q       <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      rptr_q       <= rptr_nxt;
      rgray        <= rptr_nxt ^ (rptr_nxt >> 1);
      empty        <= occ_nxt == '0;
      almost_empty <= occ_nxt <= {1'b0, ae_off};
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst_ptr) (empty && rd_en) |=> $stable(rptr_q)); // R3
  AST_EMPTY_IS_ALMOST: assert property (@(posedge rclk) disable iff (rst_ptr) empty |-> almost_empty); // R5
  AST_OCC_BOUNDED: assert property (@(posedge rclk) disable iff (rst_ptr) (wsync_bin - rptr_q) <= PW'(DEPTH)); // R3
endmodule

// File: rtl/pflag_fifo.sv
`timescale 1ns/1ps
module pflag_fifo #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic [2:0]    preset_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ser_en,
  input  logic          ser_din,
  input  logic          rd_en,
  input  logic          oe,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld,
  output logic          empty,
  output logic          full,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int PW = AW + 1;

  logic          rst_ptr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0] waddr, raddr, ae_off;
  logic          we, re;
  logic [DW-1:0] ram_q;

  assign rst_ptr = mrst | prst;

  pff_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_ptr(rst_ptr), .mrst(mrst), .preset_sel(preset_sel),
    .wr_en(wr_en), .ser_en(ser_en), .ser_din(ser_din), .rgray_s(rgray_s),
    .wgray(wgray), .waddr(waddr), .we(we), .full(full), .half_full(half_full),
    .almost_full(almost_full), .ae_off(ae_off)
  );

  pff_rd_ctl #(.AW(AW)) u_rd (
    .rclk(rclk), .rst_ptr(rst_ptr), .rd_en(rd_en), .wgray_s(wgray_s),
    .ae_off(ae_off), .rgray(rgray), .raddr(raddr), .re(re), .empty(empty),
    .almost_empty(almost_empty)
  );

  pff_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(rst_ptr), .d(rgray), .q(rgray_s));
  pff_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rst_ptr), .d(wgray), .q(wgray_s));

  pff_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rclk), .re(re), .raddr(raddr), .rdata(ram_q)
  );

  assign rd_data = oe ? ram_q : '0;
  assign rd_vld  = oe;

  AST_RESET_EMPTY: assert property (@(posedge rclk) disable iff (mrst) $past(prst) |-> empty); // R9
endmodule

// File: tb/pflag_fifo_bench.sv
`timescale 1ns/1ps
module pflag_fifo_bench;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  always #4 wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  logic mrst = 1'b1, prst = 1'b0, wr_en = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
  logic rd_en = 1'b0, oe = 1'b1;
  logic [2:0] preset_sel = 3'd0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_vld, empty, full, half_full, almost_empty, almost_full;

  pflag_fifo #(.DW(DW), .AW(AW)) u_pflag_fifo (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .preset_sel(preset_sel),
    .wr_en(wr_en), .wr_data(wr_data), .ser_en(ser_en), .ser_din(ser_din),
    .rd_en(rd_en), .oe(oe), .rd_data(rd_data), .rd_vld(rd_vld), .empty(empty),
    .full(full), .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  int nvec = 0, nerr = 0, accepted = 0, popped = 0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] seed = 16'h1000;
  bit pend = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each consumed word against the scoreboard queue
  always begin
    logic [DW-1:0] e;
    @(negedge rclk);
    if (pend) begin
      popped++;
      if (sb.size() == 0) chk(1'b0, "R1 unexpected read data", 32'(rd_data), 32'hFFFFFFFF);
      else begin
        e = sb.pop_front();
        chk(rd_data === e, "R1 read order", 32'(rd_data), 32'(e));
      end
    end
    #2;
    pend = rd_en && !empty && !mrst && !prst;
  end

  task automatic settle();
    repeat (6) @(negedge rclk);
    @(negedge wclk); #2;
  endtask

  task automatic do_reset(input bit master, input logic [2:0] sel);
    @(negedge wclk); #1;
    wr_en = 1'b0; ser_en = 1'b0; rd_en = 1'b0; preset_sel = sel;
    if (master) mrst = 1'b1; else prst = 1'b1;
    repeat (8) @(negedge rclk);
    sb.delete();
    @(negedge wclk); #1;
    mrst = 1'b0; prst = 1'b0;
    settle();
  endtask

  task automatic wr_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); #1;
      wr_en = 1'b1; wr_data = seed; seed++;
      if (!full) begin sb.push_back(wr_data); accepted++; end
    end
    @(negedge wclk); #1 wr_en = 1'b0;
    settle();
  endtask

  task automatic rd_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk); #1 rd_en = 1'b1;
    end
    @(negedge rclk); #1 rd_en = 1'b0;
    settle();
  endtask

  task automatic ser_load(input logic [AW-1:0] ae_v, input logic [AW-1:0] af_v);
    for (int i = 0; i < 2 * AW; i++) begin
      @(negedge wclk); #1;
      ser_en = 1'b1;
      ser_din = (i < AW) ? ae_v[i] : af_v[i - AW];
    end
    @(negedge wclk); #1 ser_en = 1'b0;
    settle();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    report();
  end

  initial begin
    do_reset(1'b1, 3'd0);
    // R10 reset state
    chk(empty == 1'b1, "R10 empty after mrst", 32'(empty), 1);
    chk(full == 1'b0, "R10 full after mrst", 32'(full), 0);
    chk(half_full == 1'b0, "R10 half_full after mrst", 32'(half_full), 0);
    chk(almost_empty == 1'b1, "R10 almost_empty after mrst", 32'(almost_empty), 1);
    chk(almost_full == 1'b0, "R10 almost_full after mrst", 32'(almost_full), 0);

    // R11 output qualifier
    oe = 1'b0; #1;
    chk(rd_vld == 1'b0, "R11 rd_vld with oe low", 32'(rd_vld), 0);
    chk(rd_data === '0, "R11 rd_data with oe low", 32'(rd_data), 0);
    oe = 1'b1; #1;
    chk(rd_vld == 1'b1, "R11 rd_vld with oe high", 32'(rd_vld), 1);

    // R5 / R4 / R6 with preset 7
    accepted = 0;
    wr_burst(7);
    chk(almost_empty == 1'b1, "R5 occupancy 7 of thr 7", 32'(almost_empty), 1);
    wr_burst(1);
    chk(almost_empty == 1'b0, "R5 occupancy 8 of thr 7", 32'(almost_empty), 0);
    wr_burst(24);
    chk(half_full == 1'b0, "R4 occupancy 32", 32'(half_full), 0);
    wr_burst(1);
    chk(half_full == 1'b1, "R4 occupancy 33", 32'(half_full), 1);
    wr_burst(23);
    chk(almost_full == 1'b0, "R6 free 8 of thr 7", 32'(almost_full), 0);
    wr_burst(1);
    chk(almost_full == 1'b1, "R6 free 7 of thr 7", 32'(almost_full), 1);

    // R2 overfill by four
    wr_burst(11);
    chk(full == 1'b1, "R2 full at depth", 32'(full), 1);
    chk(accepted == DEPTH, "R2 accepted count", 32'(accepted), 32'(DEPTH));

    // R1 / R3 drain and read past empty
    popped = 0;
    rd_burst(DEPTH + 6);
    chk(popped == DEPTH, "R1 words drained", 32'(popped), 32'(DEPTH));
    chk(empty == 1'b1, "R3 empty after drain", 32'(empty), 1);
    rd_burst(10);
    wr_burst(1);
    rd_burst(3);
    chk(popped == DEPTH + 1, "R3 word after empty reads", 32'(popped), 32'(DEPTH + 1));
    chk(sb.size() == 0, "R3 scoreboard drained", 32'(sb.size()), 0);

    // R7 presets
    do_reset(1'b1, 3'd2);
    wr_burst(32);
    chk(almost_full == 1'b0, "R7 sel2 free 32", 32'(almost_full), 0);
    wr_burst(1);
    chk(almost_full == 1'b1, "R7 sel2 free 31", 32'(almost_full), 1);
    do_reset(1'b1, 3'd5);
    chk(almost_full == 1'b0, "R7 sel5 limited, free 64", 32'(almost_full), 0);
    wr_burst(1);
    chk(almost_full == 1'b1, "R7 sel5 limited, free 63", 32'(almost_full), 1);

    // R8 serial load: empty thr 3, full thr 5
    do_reset(1'b1, 3'd0);
    ser_load(6'd3, 6'd5);
    wr_burst(3);
    chk(almost_empty == 1'b1, "R8 occupancy 3 of thr 3", 32'(almost_empty), 1);
    wr_burst(1);
    chk(almost_empty == 1'b0, "R8 occupancy 4 of thr 3", 32'(almost_empty), 0);
    wr_burst(54);
    chk(almost_full == 1'b0, "R8 free 6 of thr 5", 32'(almost_full), 0);
    wr_burst(1);
    chk(almost_full == 1'b1, "R8 free 5 of thr 5", 32'(almost_full), 1);

    // R9 partial reset keeps thresholds
    do_reset(1'b0, 3'd7);
    chk(empty == 1'b1, "R9 empty after prst", 32'(empty), 1);
    chk(full == 1'b0, "R9 full after prst", 32'(full), 0);
    chk(almost_full == 1'b0, "R9 almost_full after prst", 32'(almost_full), 0);
    wr_burst(3);
    chk(almost_empty == 1'b1, "R9 occupancy 3 kept thr 3", 32'(almost_empty), 1);
    wr_burst(1);
    chk(almost_empty == 1'b0, "R9 occupancy 4 kept thr 3", 32'(almost_empty), 0);
    popped = 0;
    rd_burst(6);
    chk(popped == 4, "R9 data after prst", 32'(popped), 4);

    // R10 master reset restores preset
    do_reset(1'b1, 3'd0);
    wr_burst(4);
    chk(almost_empty == 1'b1, "R10 preset 7 restored", 32'(almost_empty), 1);

    report();
  end
endmodule